// File: doc/BRIEF.md
# Aligned Multi-Ratio Clock Divider

This block derives two slower clocks from one input clock. The first runs at half the input rate. The second runs at a quarter or a sixth of the input rate, and a select input picks which. Both outputs advance from one shared position counter, so each rising edge of the slower output coincides exactly with a rising edge of the half-rate output. A one-cycle marker flags every input cycle in which both outputs rise together. Downstream logic can use it to line up other timing, or to confirm that several copies of the block run in step.

Everything runs in the input-clock domain. Each output is a register, and a clock-enable decides whether the registers advance. A hold request is captured on the falling input edge, so the rising edge that follows either advances the dividers or freezes them. A freeze therefore never cuts an output pulse short. A synchronous reset clears the block. When the same reset is given to several instances, they all start on the same cycle.

The ratio select is sampled only when a slow-output period ends. A change in ratio therefore starts a fresh, complete period and never produces a shortened one.

Top module: `aligned_clkdiv`

## Requirements
- R1: While not held, `half_o` toggles on every rising input edge. The first enabled edge after reset drives it high.
- R2: With the active ratio select at 0, `slow_o` has a period of 4 input cycles: high for 2, then low for 2. With the select at 1, the period is 6 cycles: high for 3, then low for 3. Every period starts with the high part, and the first enabled edge after reset drives the output high.
- R3: A rising edge that is governed by an active hold leaves `half_o` and `slow_o` unchanged and drives `sync_o` low.
- R4: The value of `hold_i` at the falling input edge governs the next rising edge. A change of `hold_i` between that falling edge and the rising edge has no effect on that rising edge.
- R5: When `rst` is high at a rising edge, all three outputs are low after that edge, whatever the value of `hold_i`. Counting restarts from the beginning of a period.
- R6: `sync_o` is high for exactly the one input cycle that follows an edge on which `half_o` and `slow_o` both rose. It is low in all other cycles.
- R7: `ratio_sel_i` is sampled at reset and on the last enabled edge of each slow period. Its value takes effect from the next period onward, so no period of `slow_o` is ever shortened.
- R8: Every rising edge of `slow_o` happens on the same input edge as a rising edge of `half_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| hold_i | input | 1 | 1 freezes the dividers; captured on the falling clock edge |
| ratio_sel_i | input | 1 | Slow-output ratio: 0 selects 4, 1 selects 6 |
| half_o | output | 1 | Divide-by-2 output |
| slow_o | output | 1 | Divide-by-4 or divide-by-6 output |
| sync_o | output | 1 | One-cycle pulse marking a common rising edge |

## Verification
If the position counter is corrupted, it throws off the period or the duty of `slow_o`. It also moves `sync_o` away from the common rising edges. Either symptom appears within one slow period, which is at most six input cycles. A fault in the falling-edge hold capture shows on the very next rising edge, because the outputs move when they should stay put, or stay put when they should move. A ratio select that takes effect too early shows up as a truncated `slow_o` period right after the select changes.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // Counter width able to hold positions 0 .. max_ratio-1
  function automatic int pos_width(input int max_ratio);
    return (max_ratio < 2) ? 1 : $clog2(max_ratio);
  endfunction
endpackage

// File: rtl/clkdiv_hold_capture.sv
// Captures the hold request on the falling edge, so the following rising
// edge sees a value that has been settled for half a cycle.
module clkdiv_hold_capture (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  output logic hold_q
);
  always_ff @(negedge clk) begin
    if (rst) hold_q <= 1'b0;
    else     hold_q <= hold_i;
  end
endmodule

// File: rtl/clkdiv_position.sv
// Shared position counter and active-ratio register.
module clkdiv_position #(
  parameter int RATIO_LO = 4,
  parameter int RATIO_HI = 6,
  localparam int CW = clkdiv_pkg::pos_width(RATIO_HI)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          ratio_sel_i,
  output logic [CW-1:0] pos_o,
  output logic          sel_o
);
  localparam logic [CW-1:0] LAST_LO = CW'(RATIO_LO - 1);
  localparam logic [CW-1:0] LAST_HI = CW'(RATIO_HI - 1);

  logic [CW-1:0] pos_q;
  logic          sel_q;
  logic [CW-1:0] last;
  logic          at_end;

  always_comb begin
    last   = sel_q ? LAST_HI : LAST_LO;
    at_end = (pos_q == last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      sel_q <= ratio_sel_i;
    end else if (adv) begin
      if (at_end) begin
        pos_q <= '0;
        sel_q <= ratio_sel_i;
      end else begin
        pos_q <= pos_q + CW'(1);
      end
    end
  end

  assign pos_o = pos_q;
  assign sel_o = sel_q;

  assert_pos_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    pos_q <= last);

  assert_sel_only_at_start_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_q) |-> (pos_q == '0));
endmodule

// File: rtl/clkdiv_outputs.sv
// Registered divided outputs and phase marker, decoded from the position.
module clkdiv_outputs #(
  parameter int RATIO_LO = 4,
  parameter int RATIO_HI = 6,
  localparam int CW = clkdiv_pkg::pos_width(RATIO_HI)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [CW-1:0] pos_i,
  input  logic          sel_i,
  output logic          half_o,
  output logic          slow_o,
  output logic          sync_o
);
  localparam logic [CW-1:0] HALF_LO = CW'(RATIO_LO / 2);
  localparam logic [CW-1:0] HALF_HI = CW'(RATIO_HI / 2);

  logic [CW-1:0] high_len;
  assign high_len = sel_i ? HALF_HI : HALF_LO;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_o <= 1'b0;
      slow_o <= 1'b0;
      sync_o <= 1'b0;
    end else if (adv) begin
      half_o <= ~pos_i[0];
      slow_o <= (pos_i < high_len);
      sync_o <= (pos_i == '0);
    end else begin
      sync_o <= 1'b0;
    end
  end

  assert_clear_on_reset_R5: assert property (@(posedge clk)
    rst |=> (!half_o && !slow_o && !sync_o));

  assert_half_toggles_R1: assert property (@(posedge clk) disable iff (rst)
    adv |=> (half_o != $past(half_o)));

  assert_hold_freezes_R3: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(half_o) && $stable(slow_o) && !sync_o));

  assert_sync_on_common_rise_R6: assert property (@(posedge clk) disable iff (rst)
    sync_o |-> (half_o && slow_o && !$past(half_o) && !$past(slow_o)));

  assert_sync_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    sync_o |=> !sync_o);

  assert_slow_rise_aligned_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(slow_o) |-> $rose(half_o));
endmodule

// File: rtl/aligned_clkdiv.sv
// Both ratios must be even and RATIO_HI greater than RATIO_LO.
module aligned_clkdiv #(
  parameter int RATIO_LO = 4,
  parameter int RATIO_HI = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  input  logic ratio_sel_i,
  output logic half_o,
  output logic slow_o,
  output logic sync_o
);
  localparam int CW = clkdiv_pkg::pos_width(RATIO_HI);

  logic          hold_q;
  logic          adv;
  logic [CW-1:0] pos;
  logic          sel_act;

  clkdiv_hold_capture u_hold (
    .clk    (clk),
    .rst    (rst),
    .hold_i (hold_i),
    .hold_q (hold_q)
  );

  assign adv = ~hold_q;

  clkdiv_position #(.RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI)) u_pos (
    .clk         (clk),
    .rst         (rst),
    .adv         (adv),
    .ratio_sel_i (ratio_sel_i),
    .pos_o       (pos),
    .sel_o       (sel_act)
  );

  clkdiv_outputs #(.RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI)) u_out (
    .clk    (clk),
    .rst    (rst),
    .adv    (adv),
    .pos_i  (pos),
    .sel_i  (sel_act),
    .half_o (half_o),
    .slow_o (slow_o),
    .sync_o (sync_o)
  );
endmodule

// File: tb/test_aligned_clkdiv.sv
module test_aligned_clkdiv;
  localparam int RLO = 4;
  localparam int RHI = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold_i = 1'b0;
  logic ratio_sel_i = 1'b0;
  logic half_o, slow_o, sync_o;

  int n_cmp = 0;
  int n_bad = 0;

  // reference state
  int  pos = 0;
  int  ratio = RLO;
  logic e_half = 1'b0, e_slow = 1'b0, e_sync = 1'b0;
  logic p_half = 1'b0, p_slow = 1'b0;

  always #4 clk = ~clk;

  aligned_clkdiv #(.RATIO_LO(RLO), .RATIO_HI(RHI)) i_aligned_clkdiv (
    .clk(clk), .rst(rst), .hold_i(hold_i), .ratio_sel_i(ratio_sel_i),
    .half_o(half_o), .slow_o(slow_o), .sync_o(sync_o)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // advance the reference by one rising edge
  task automatic model_edge(input logic h, input logic s);
    if (h) begin
      e_sync = 1'b0;
    end else begin
      e_half = (pos % 2) == 0;
      e_slow = pos < (ratio / 2);
      e_sync = (pos == 0);
      if (pos == ratio - 1) begin
        pos = 0;
        ratio = s ? RHI : RLO;
      end else begin
        pos++;
      end
    end
  endtask

  task automatic compare(input string tag);
    chk((tag == "") ? "R1" : tag, "half_o", half_o, e_half);
    chk((tag == "") ? "R2" : tag, "slow_o", slow_o, e_slow);
    chk((tag == "") ? "R6" : tag, "sync_o", sync_o, e_sync);
    if (slow_o && !p_slow) chk("R8", "half_o rising with slow_o", half_o && !p_half, 1'b1);
    p_half = half_o;
    p_slow = slow_o;
  endtask

  task automatic tick(input logic h, input logic s, input string tag);
    hold_i = h;
    ratio_sel_i = s;
    @(posedge clk); #2;
    model_edge(h, s);
    compare(h ? "R3" : tag);
  endtask

  // hold flips after the falling edge; only the captured value may count
  task automatic late_tick(input logic h, input logic s);
    hold_i = h;
    ratio_sel_i = s;
    @(negedge clk); #1;
    hold_i = ~h;
    @(posedge clk); #2;
    model_edge(h, s);
    compare("R4");
  endtask

  task automatic do_reset(input logic h, input logic s);
    rst = 1'b1;
    hold_i = h;
    ratio_sel_i = s;
    @(posedge clk); #2;
    chk("R5", "half_o", half_o, 1'b0);
    chk("R5", "slow_o", slow_o, 1'b0);
    chk("R5", "sync_o", sync_o, 1'b0);
    pos = 0;
    ratio = s ? RHI : RLO;
    e_half = 0; e_slow = 0; e_sync = 0;
    p_half = 0; p_slow = 0;
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(posedge clk); #2;
    @(posedge clk); #2;
    do_reset(1'b0, 1'b0);
    // divide by 4 free run
    for (int i = 0; i < 24; i++) tick(1'b0, 1'b0, "");
    // reset while hold is requested, select 6
    do_reset(1'b1, 1'b1);
    for (int i = 0; i < 30; i++) tick(1'b0, 1'b1, "");
    // freeze and resume
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b1, "R3");
    for (int i = 0; i < 10; i++) tick(1'b0, 1'b1, "");
    // ratio changes at arbitrary points
    for (int i = 0; i < 60; i++) tick(1'b0, ((i / 7) % 2) == 1, "R7");
    // late hold changes
    for (int i = 0; i < 12; i++) late_tick(i[0], 1'b0);
    // near-exhaustive: every 4-edge hold pattern with each ratio
    for (int s = 0; s < 2; s++) begin
      do_reset(1'b0, s[0]);
      for (int pat = 0; pat < 16; pat++) begin
        for (int b = 0; b < 4; b++) tick(pat[b], s[0], "");
        for (int b = 0; b < 3; b++) tick(1'b0, s[0], "");
      end
    end
    // reset in mid-run
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b1, "");
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) tick(1'b0, 1'b0, "");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule